// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational adder for two unsigned (or two's-complement) operands plus a carry input. It gives the sum and the carry out in a single combinational pass, with no clock, no registers and no reset. Its structure is meant for wide adders where a rippling carry would be too slow.

Each bit position forms a generate term (the AND of the operand bits) and a propagate term (their XOR). The operand is cut into groups of `RADIX` bits. One lookahead cell per group turns its generate and propagate terms into that group's internal carries, using fully expanded sum-of-products logic, and into one block generate and one block propagate. A second-level cell of the same design takes the group block terms and the carry input. From them it forms the carry into every group and the top-level block terms, and those give the carry out. No carry passes directly from one group to the next.

The width is set by `RADIX`, and the default of 4 gives a 16-bit adder. The width must be exactly `RADIX*RADIX`, so that two levels of the same cell cover it. Elaboration stops if the parameters break this rule.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals `(a_i + b_i + c_i)` modulo 2^WIDTH for every operand pair and both values of `c_i`.
- R2: `c_o` equals bit WIDTH (the bit above the MSB) of the full-width result `a_i + b_i + c_i`.
- R3: When every bit of a group propagates (operand bits differ at all RADIX positions of the group), the carry leaving that group equals the carry entering it. For example, `a_i=16'hFFFF`, `b_i=0`, `c_i=1` gives `sum_o=0` and `c_o=1`.
- R4: A group whose top bit pair is both 1 produces a carry out of that group whatever its carry in. For example, `a_i=16'h0008`, `b_i=16'h0008`, `c_i=0` gives `sum_o=16'h0010`.
- R5: The carry into each group equals the carry out of the arithmetic sum of all lower bits with `c_i`. It is supplied by the second-level cell and is never taken from the neighbouring group's output.
- R6: Inside any lookahead cell, block generate and block propagate are never both 1. When block propagate is 1, the cell's last internal carry equals its carry in.
- R7: With `a_i=b_i=0`, `c_i` alone sets `sum_o[0]`, and `c_o` stays 0.
- R8: Elaboration fails unless `RADIX >= 2` and `WIDTH == RADIX*RADIX`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| c_o | output | 1 | Carry out of the MSB |

## Verification
Carry creation inside one group and carry passing across whole groups can happen in the same addition. This occurs when a low group generates and every group above it only propagates, so that the second-level cell must pass a generated carry through several all-propagate groups to the carry out. The bench provokes this with operands such as `16'hFFF8 + 16'h0008` and with a sweep that sets each nibble to generate, propagate or kill patterns. It judges every case against a 17-bit behavioural sum, including `sum_o` and `c_o`.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
   // Default lookahead cell fan-in; two levels give RADIX*RADIX bits.
   localparam int unsigned CLA2_RADIX_DEF = 4;
   localparam int unsigned CLA2_WIDTH_DEF = CLA2_RADIX_DEF * CLA2_RADIX_DEF;
endpackage

// File: rtl/cla2_bit_gp.sv
module cla2_bit_gp #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] gen_o,
   output logic [W-1:0] prop_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen_o[i]  = a_i[i] & b_i[i];
      assign prop_o[i] = a_i[i] ^ b_i[i];
   end
endmodule

// File: rtl/cla2_cell.sv
module cla2_cell #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] gen_i,
   input  logic [N-1:0] prop_i,
   input  logic         cin_i,
   output logic [N-1:0] carry_o,
   output logic         bgen_o,
   output logic         bprop_o
);
   if (N < 2) begin : g_bad_n
      $error("cla2_cell: N must be at least 2");
   end

   logic term;
   logic acc;

   // Fully expanded carries: carry_o[k] enters position k of the block.
   always_comb begin
      carry_o = '0;
      for (int k = 0; k < N; k++) begin
         term = cin_i;
         for (int j = 0; j < k; j++) term = term & prop_i[j];
         acc = term;
         for (int j = 0; j < k; j++) begin
            term = gen_i[j];
            for (int m = j + 1; m < k; m++) term = term & prop_i[m];
            acc = acc | term;
         end
         carry_o[k] = acc;
      end
   end

   logic bg_acc;
   logic bg_term;
   always_comb begin
      bg_acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         bg_term = gen_i[j];
         for (int m = j + 1; m < N; m++) bg_term = bg_term & prop_i[m];
         bg_acc = bg_acc | bg_term;
      end
      bgen_o  = bg_acc;
      bprop_o = &prop_i;
   end

   always_comb begin
      if (!$isunknown({gen_i, prop_i, cin_i})) begin
         // R6
         gp_excl_chk: assert (!(bgen_o && bprop_o))
            else $error("block generate and propagate both set");
         // R6
         pass_through_chk: assert (!bprop_o || (carry_o[N-1] == cin_i))
            else $error("all-propagate block altered its carry");
      end
   end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
   import cla2_pkg::*;
#(
   parameter int unsigned RADIX = CLA2_RADIX_DEF,
   parameter int unsigned WIDTH = CLA2_WIDTH_DEF
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_o
);
   localparam int unsigned NGRP = WIDTH / RADIX;

   // R8
   if (RADIX < 2 || WIDTH != RADIX * RADIX) begin : g_bad_shape
      $error("cla2_adder: WIDTH must equal RADIX*RADIX with RADIX >= 2");
   end

   logic [WIDTH-1:0] bit_gen, bit_prop, bit_carry;
   logic [NGRP-1:0]  grp_gen, grp_prop, grp_cin;
   logic             top_gen, top_prop;

   cla2_bit_gp #(.W(WIDTH)) u_gp (
      .a_i    (a_i),
      .b_i    (b_i),
      .gen_o  (bit_gen),
      .prop_o (bit_prop)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      cla2_cell #(.N(RADIX)) u_cell (
         .gen_i   (bit_gen[g*RADIX +: RADIX]),
         .prop_i  (bit_prop[g*RADIX +: RADIX]),
         .cin_i   (grp_cin[g]),
         .carry_o (bit_carry[g*RADIX +: RADIX]),
         .bgen_o  (grp_gen[g]),
         .bprop_o (grp_prop[g])
      );
   end

   cla2_cell #(.N(NGRP)) u_top (
      .gen_i   (grp_gen),
      .prop_i  (grp_prop),
      .cin_i   (c_i),
      .carry_o (grp_cin),
      .bgen_o  (top_gen),
      .bprop_o (top_prop)
   );

   assign sum_o = bit_prop ^ bit_carry;
   assign c_o   = top_gen | (top_prop & c_i);

   logic [WIDTH:0] ref_full;
   logic [WIDTH:0] ref_low;
   always_comb begin
      ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
      if (!$isunknown({a_i, b_i, c_i})) begin
         // R1
         sum_match_chk: assert (sum_o == ref_full[WIDTH-1:0])
            else $error("sum mismatch");
         // R2
         carry_out_chk: assert (c_o == ref_full[WIDTH])
            else $error("carry out mismatch");
         for (int g = 1; g < NGRP; g++) begin
            ref_low = ({1'b0, a_i & ((1 << (g*RADIX)) - 1)})
                    + ({1'b0, b_i & ((1 << (g*RADIX)) - 1)})
                    + {{WIDTH{1'b0}}, c_i};
            // R5
            group_cin_chk: assert (grp_cin[g] == ref_low[g*RADIX])
               else $error("group carry-in mismatch");
         end
      end
   end
endmodule

// File: tb/cla2_adder_test.sv
`timescale 1ns/1ps
module cla2_adder_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] a, b, s;
   logic         ci, co;
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   cla2_adder uut (
      .a_i(a), .b_i(b), .c_i(ci), .sum_o(s), .c_o(co)
   );

   task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y,
                              input logic cc, input string req);
      logic [W:0] exp;
      @(negedge clk);
      a = x; b = y; ci = cc;
      @(posedge clk);
      #1;
      exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cc};
      checks++;
      if ({co, s} !== exp) begin
         fails++;
         $display("FAIL %s: a=%h b=%h ci=%b got %b_%h expected %b_%h",
                  req, x, y, cc, co, s, exp[W], exp[W-1:0]);
      end
   endtask

   // R7: carry-in alone on zero operands
   task automatic t_zero();
      apply_check(16'h0000, 16'h0000, 1'b0, "R7");
      apply_check(16'h0000, 16'h0000, 1'b1, "R7");
   endtask

   // R3: carry travels through all-propagate groups
   task automatic t_propagate();
      apply_check(16'hFFFF, 16'h0000, 1'b1, "R3");
      apply_check(16'hFFFF, 16'h0000, 1'b0, "R3");
      apply_check(16'hAAAA, 16'h5555, 1'b1, "R3");
      apply_check(16'h0F0F, 16'hF0F0, 1'b1, "R3");
   endtask

   // R4 with R5: generated carry crossing propagate groups
   task automatic t_generate();
      apply_check(16'h0008, 16'h0008, 1'b0, "R4");
      apply_check(16'hFFF8, 16'h0008, 1'b0, "R4");
      apply_check(16'h8000, 16'h8000, 1'b0, "R4");
      apply_check(16'h0800, 16'h0F00, 1'b1, "R5");
   endtask

   // R5: each nibble set to kill / propagate / generate / mixed
   task automatic t_nibble_sweep();
      logic [3:0] pa [4] = '{4'h0, 4'hF, 4'hF, 4'h7};
      logic [3:0] pb [4] = '{4'h0, 4'h0, 4'hF, 4'h1};
      for (int code = 0; code < 256; code++) begin
         logic [W-1:0] x, y;
         for (int n = 0; n < 4; n++) begin
            x[n*4 +: 4] = pa[(code >> (2*n)) & 3];
            y[n*4 +: 4] = pb[(code >> (2*n)) & 3];
         end
         apply_check(x, y, code[0], "R5");
         apply_check(x, y, ~code[0], "R5");
      end
   endtask

   // R1 and R2: random operands
   task automatic t_random();
      for (int i = 0; i < 2000; i++) begin
         apply_check(W'($urandom), W'($urandom), 1'($urandom), "R1");
      end
      apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R2");
      apply_check(16'h7FFF, 16'h0001, 1'b0, "R2");
   endtask

   initial begin
      a = '0; b = '0; ci = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_zero();
      t_propagate();
      t_generate();
      t_nibble_sweep();
      t_random();
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule